// File: doc/BRIEF.md
# Prioritized interrupt vector unit

This unit sits beside the control sequencer of a small 8-bit processor and decides which interrupt is taken at each instruction boundary. It collects five hardware sources: a non-maskable trap, three vectored restart lines (levels 5.5, 6.5 and 7.5) and a general interrupt line. It also takes a software restart request from the decoder. A global enable flag and a three-bit mask register gate the maskable sources. Software writes the mask through a mask-write port and reads a pending/enable status byte back.

When the sequencer pulses the boundary strobe, the unit picks the highest-priority eligible request. It registers that request's 16-bit vector address and raises a valid flag. Vector and flag hold until the sequencer acknowledges. The acknowledge clears the edge latch that belongs to the taken source, and for a maskable source it also clears the global enable. Pushing the program counter is left to the sequencer.

Top module: `ivu_core`

## Requirements
- R1: After reset `vec_valid_o` is 0, `mask_o` is 3'b111 (every maskable restart masked) and `status_o` is 8'h00.
- R2: A mask write (`mask_we_i`) loads `mask_wdata_i[2:0]` into the mask only when `mask_wdata_i[3]` is 1. Otherwise the mask is unchanged. Bits 7:4 of the written data, bit 5 included, never affect the mask. Mask bit 0 belongs to 5.5, bit 1 to 6.5 and bit 2 to 7.5, and a 1 masks the source.
- R3: `status_o` shows bit 0 = 5.5 pending, bit 1 = 6.5 pending, bit 2 = 7.5 latch, bit 3 = global enable, bit 4 = trap latch, bit 5 = general line pending, and bits 7:6 = 0. Each bit reflects the inputs sampled at the previous clock edge.
- R4: `ie_set_i` sets the global enable and `ie_clr_i` clears it. If both are high in the same cycle, set wins.
- R5: The priority order is trap, 7.5, 6.5, 5.5, general line, software restart. The vectors are 0x0024, 0x003C, 0x0034, 0x002C, 0x0038 and 8×n respectively.
- R6: The trap is taken regardless of the global enable and the mask.
- R7: A restart line whose mask bit is set, and every maskable source while the global enable is 0, is never selected, yet it still shows as pending in `status_o`.
- R8: The trap and 7.5 inputs are latched on a rising edge. The latch stays set after the input falls and is cleared only when its own vector is acknowledged.
- R9: Acknowledging a 7.5, 6.5, 5.5 or general-line vector clears the global enable. Acknowledging a trap or software restart leaves it unchanged.
- R10: A boundary strobe with an eligible request raises `vec_valid_o` on the next edge. The vector stays stable until `ack_i`, after which `vec_valid_o` is 0 on the following edge. Boundary strobes seen while a vector is outstanding are ignored.
- R11: A software restart n (`soft_num_i`) is taken with vector 8×n only if no hardware source wins, and it does not depend on the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Non-maskable trap request (edge latched) |
| rq75_i | input | 1 | Restart 7.5 request (edge latched) |
| rq65_i | input | 1 | Restart 6.5 request (level) |
| rq55_i | input | 1 | Restart 5.5 request (level) |
| intr_i | input | 1 | General interrupt request (level) |
| ie_set_i | input | 1 | Set global enable |
| ie_clr_i | input | 1 | Clear global enable |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| status_o | output | 8 | Pending and enable status byte |
| mask_o | output | 3 | Current mask bits |
| boundary_i | input | 1 | Instruction boundary strobe |
| soft_req_i | input | 1 | Software restart request |
| soft_num_i | input | 3 | Software restart number n |
| vec_valid_o | output | 1 | Vector offered to the sequencer |
| vec_addr_o | output | 16 | Vector address |
| ack_i | input | 1 | Sequencer acknowledge of the offered vector |

## Verification
Every stimulus is applied at a falling edge. Status bits, the mask and the enable are due one rising edge later, so the bench reads them at the next falling edge. The vector is registered at the edge that samples the boundary strobe and is read at the falling edge after it. The effect of an acknowledge (valid dropped, enable and latch cleared) is also due one edge later and is read at the falling edge that follows. The sweep covers every combination of the six requests, both enable states and all eight masks, and runs each case from reset so that the edge latches start from a known state.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
    localparam int VEC_W   = 16;
    localparam int MSK_W   = 3;
    localparam int NUM_W   = 3;
    localparam int STAT_W  = 8;
    localparam int EDGE_N  = 2;

    localparam logic [VEC_W-1:0] TRAP_VEC = 16'h0024;
    localparam logic [VEC_W-1:0] R55_VEC  = 16'h002C;
    localparam logic [VEC_W-1:0] R65_VEC  = 16'h0034;
    localparam logic [VEC_W-1:0] R75_VEC  = 16'h003C;
    localparam logic [VEC_W-1:0] INTR_VEC = 16'h0038;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_TRAP, SRC_R75, SRC_R65, SRC_R55, SRC_INTR, SRC_SOFT
    } src_e;

    typedef struct packed {
        logic [MSK_W-1:0] mask;
        logic             ie;
        logic             r55;
        logic             r65;
        logic             intr;
        logic             valid;
        logic [VEC_W-1:0] vec;
        src_e             src;
    } ivu_state_t;

    function automatic logic [VEC_W-1:0] soft_vec(input logic [NUM_W-1:0] n);
        return VEC_W'({n, 3'b000});
    endfunction

    function automatic logic is_maskable(input src_e s);
        return (s == SRC_R75) || (s == SRC_R65) || (s == SRC_R55) || (s == SRC_INTR);
    endfunction
endpackage

// File: rtl/ivu_edge_latch.sv
module ivu_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clear_i,
    output logic pend_o
);
    logic prev_d, prev_q;
    logic pend_d, pend_q;
    logic rise;

    always_comb begin
        rise   = level_i && !prev_q;
        prev_d = level_i;
        pend_d = pend_q;
        if (clear_i) pend_d = 1'b0;
        if (rise)    pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R8
    edge_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i && !prev_q) |=> pend_q);

    // R8
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !(level_i && !prev_q)) |=> !pend_q);
endmodule

// File: rtl/ivu_arbiter.sv
module ivu_arbiter
    import ivu_pkg::*;
(
    input  logic             trap_p,
    input  logic             r75_p,
    input  logic             r65_p,
    input  logic             r55_p,
    input  logic             intr_p,
    input  logic             ie,
    input  logic [MSK_W-1:0] mask,
    input  logic             soft_req,
    input  logic [NUM_W-1:0] soft_num,
    output logic             hit,
    output src_e             src,
    output logic [VEC_W-1:0] vec
);
    logic [5:0] grant;

    always_comb begin
        grant = '0;
        src   = SRC_NONE;
        vec   = '0;
        if (trap_p) begin
            grant[0] = 1'b1; src = SRC_TRAP; vec = TRAP_VEC;
        end else if (ie && r75_p && !mask[2]) begin
            grant[1] = 1'b1; src = SRC_R75;  vec = R75_VEC;
        end else if (ie && r65_p && !mask[1]) begin
            grant[2] = 1'b1; src = SRC_R65;  vec = R65_VEC;
        end else if (ie && r55_p && !mask[0]) begin
            grant[3] = 1'b1; src = SRC_R55;  vec = R55_VEC;
        end else if (ie && intr_p) begin
            grant[4] = 1'b1; src = SRC_INTR; vec = INTR_VEC;
        end else if (soft_req) begin
            grant[5] = 1'b1; src = SRC_SOFT; vec = soft_vec(soft_num);
        end
        hit = |grant;
    end

    // R5
    always_comb begin
        one_grant_chk: assert ($onehot0(grant));
    end
endmodule

// File: rtl/ivu_core.sv
module ivu_core
    import ivu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_i,
    input  logic              rq75_i,
    input  logic              rq65_i,
    input  logic              rq55_i,
    input  logic              intr_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              mask_we_i,
    input  logic [STAT_W-1:0] mask_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [MSK_W-1:0]  mask_o,
    input  logic              boundary_i,
    input  logic              soft_req_i,
    input  logic [NUM_W-1:0]  soft_num_i,
    output logic              vec_valid_o,
    output logic [VEC_W-1:0]  vec_addr_o,
    input  logic              ack_i
);
    ivu_state_t st_d, st_q;

    logic [EDGE_N-1:0] edge_in, edge_clr, edge_pend;
    logic              trap_pend, r75_pend;
    logic              win_hit;
    src_e              win_src;
    logic [VEC_W-1:0]  win_vec;
    logic              unused_wbits;

    assign unused_wbits = ^{mask_wdata_i[7:4]};

    assign edge_in   = {rq75_i, trap_i};
    assign trap_pend = edge_pend[0];
    assign r75_pend  = edge_pend[1];

    for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
        ivu_edge_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (edge_in[g]),
            .clear_i (edge_clr[g]),
            .pend_o  (edge_pend[g])
        );
    end

    ivu_arbiter u_arb (
        .trap_p   (trap_pend),
        .r75_p    (r75_pend),
        .r65_p    (st_q.r65),
        .r55_p    (st_q.r55),
        .intr_p   (st_q.intr),
        .ie       (st_q.ie),
        .mask     (st_q.mask),
        .soft_req (soft_req_i),
        .soft_num (soft_num_i),
        .hit      (win_hit),
        .src      (win_src),
        .vec      (win_vec)
    );

    always_comb begin
        st_d     = st_q;
        edge_clr = '0;
        st_d.r55  = rq55_i;
        st_d.r65  = rq65_i;
        st_d.intr = intr_i;
        if (mask_we_i && mask_wdata_i[3]) st_d.mask = mask_wdata_i[MSK_W-1:0];
        if (ie_set_i)      st_d.ie = 1'b1;
        else if (ie_clr_i) st_d.ie = 1'b0;
        if (st_q.valid) begin
            if (ack_i) begin
                st_d.valid = 1'b0;
                if (st_q.src == SRC_TRAP) edge_clr[0] = 1'b1;
                if (st_q.src == SRC_R75)  edge_clr[1] = 1'b1;
                if (is_maskable(st_q.src)) st_d.ie = 1'b0;
            end
        end else if (boundary_i && win_hit) begin
            st_d.valid = 1'b1;
            st_d.vec   = win_vec;
            st_d.src   = win_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mask  <= '1;
            st_q.src   <= SRC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o    = {2'b00, st_q.intr, trap_pend, st_q.ie, r75_pend, st_q.r65, st_q.r55};
    assign mask_o      = st_q.mask;
    assign vec_valid_o = st_q.valid;
    assign vec_addr_o  = st_q.vec;

    // R10
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !ack_i) |=> (st_q.valid && $stable(st_q.vec)));

    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && ack_i) |=> !st_q.valid);

    // R2
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_we_i && mask_wdata_i[3]) |=> $stable(st_q.mask));

    // R9
    ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && ack_i && is_maskable(st_q.src)) |=> !st_q.ie);

    // R6
    trap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !st_q.valid && trap_pend) |=> (st_q.valid && st_q.vec == TRAP_VEC));

    // R7
    ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !st_q.valid && !st_q.ie && !trap_pend && !soft_req_i) |=> !st_q.valid);
endmodule

// File: tb/ivu_core_test.sv
module ivu_core_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_i = 0, rq75_i = 0, rq65_i = 0, rq55_i = 0, intr_i = 0;
    logic        ie_set_i = 0, ie_clr_i = 0, mask_we_i = 0;
    logic [7:0]  mask_wdata_i = '0;
    logic [7:0]  status_o;
    logic [2:0]  mask_o;
    logic        boundary_i = 0, soft_req_i = 0;
    logic [2:0]  soft_num_i = '0;
    logic        vec_valid_o;
    logic [15:0] vec_addr_o;
    logic        ack_i = 0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivu_core uut (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rq75_i(rq75_i), .rq65_i(rq65_i),
        .rq55_i(rq55_i), .intr_i(intr_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .status_o(status_o),
        .mask_o(mask_o), .boundary_i(boundary_i), .soft_req_i(soft_req_i),
        .soft_num_i(soft_num_i), .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o),
        .ack_i(ack_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; trap_i = 0; rq75_i = 0; rq65_i = 0; rq55_i = 0; intr_i = 0;
        ie_set_i = 0; ie_clr_i = 0; mask_we_i = 0; mask_wdata_i = 0;
        boundary_i = 0; soft_req_i = 0; soft_num_i = 0; ack_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        logic [15:0] ev;
        logic        eh, emsk;
        do_reset();
        check("R1 valid", 32'(vec_valid_o), 0);
        check("R1 mask", 32'(mask_o), 32'h7);
        check("R1 status", 32'(status_o), 0);

        for (int c = 0; c < 1024; c++) begin
            logic tr, r7, r6, r5, it, sw, ie;
            logic [2:0] m;
            {tr, r7, r6, r5, it, sw} = c[5:0];
            ie = c[6];
            m  = c[9:7];
            do_reset();
            mask_we_i = 1; mask_wdata_i = {4'b0000, 1'b1, m}; ie_set_i = ie;
            trap_i = tr; rq75_i = r7; rq65_i = r6; rq55_i = r5; intr_i = it;
            soft_req_i = sw; soft_num_i = m ^ 3'b101;
            @(negedge clk);
            mask_we_i = 0; ie_set_i = 0;
            // R3 R7: pending visible regardless of mask/enable
            check("R3 R7 status", 32'(status_o), 32'({2'b00, it, tr, ie, r7, r6, r5}));
            check("R2 mask load", 32'(mask_o), 32'(m));
            boundary_i = 1;
            eh = 1; emsk = 0;
            if (tr) ev = 16'h0024;
            else if (ie && r7 && !m[2]) begin ev = 16'h003C; emsk = 1; end
            else if (ie && r6 && !m[1]) begin ev = 16'h0034; emsk = 1; end
            else if (ie && r5 && !m[0]) begin ev = 16'h002C; emsk = 1; end
            else if (ie && it)          begin ev = 16'h0038; emsk = 1; end
            else if (sw) ev = 16'({soft_num_i, 3'b000});
            else begin eh = 0; ev = 16'h0; end
            @(negedge clk);
            boundary_i = 0;
            // R5 R6 R7 R11
            check("R5 R6 R7 R11 valid", 32'(vec_valid_o), 32'(eh));
            if (eh) begin
                check("R5 R6 R11 vector", 32'(vec_addr_o), 32'(ev));
                ack_i = 1;
                @(negedge clk);
                ack_i = 0;
                check("R10 ack drop", 32'(vec_valid_o), 0);
                // R9 enable after ack, R8 latch cleared by own ack
                check("R9 ie after ack", 32'(status_o[3]), 32'(emsk ? 1'b0 : ie));
                if (ev == 16'h0024) check("R8 trap cleared", 32'(status_o[4]), 0);
                if (ev == 16'h003C) check("R8 r75 cleared", 32'(status_o[2]), 0);
            end
        end

        // R2: bit3 clear, bit5 set -> mask unchanged
        do_reset();
        mask_we_i = 1; mask_wdata_i = 8'b0010_0010;
        @(negedge clk);
        mask_we_i = 0;
        check("R2 no enable bit", 32'(mask_o), 32'h7);
        mask_we_i = 1; mask_wdata_i = 8'b1111_1000;
        @(negedge clk);
        mask_we_i = 0;
        check("R2 upper bits ignored", 32'(mask_o), 32'h0);

        // R4: set and clear together -> set wins, then clear
        ie_set_i = 1; ie_clr_i = 1;
        @(negedge clk);
        ie_set_i = 0; ie_clr_i = 0;
        check("R4 set wins", 32'(status_o[3]), 1);
        ie_clr_i = 1;
        @(negedge clk);
        ie_clr_i = 0;
        check("R4 clear", 32'(status_o[3]), 0);

        // R8: 7.5 pulse stays latched after input falls
        rq75_i = 1;
        @(negedge clk);
        rq75_i = 0;
        @(negedge clk);
        check("R8 r75 held", 32'(status_o[2]), 1);

        // R10: boundary while outstanding ignored; vector stable
        soft_req_i = 1; soft_num_i = 3'd7; boundary_i = 1;
        @(negedge clk);
        soft_req_i = 0; boundary_i = 0;
        check("R11 soft vec", 32'(vec_addr_o), 32'h38);
        trap_i = 1;
        @(negedge clk);
        boundary_i = 1;
        @(negedge clk);
        boundary_i = 0;
        check("R10 held during boundary", 32'(vec_addr_o), 32'h38);
        check("R10 still valid", 32'(vec_valid_o), 1);
        ack_i = 1;
        @(negedge clk);
        ack_i = 0;
        check("R8 trap survives other ack", 32'(status_o[4]), 1);
        check("R10 no valid without boundary", 32'(vec_valid_o), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule